// File: doc/BRIEF.md
# Expansion-Bus Refresh Sequencer with Short Host-Bus Hand-Off

This block runs DRAM-style refresh cycles on an ISA-style expansion bus while keeping the host bus occupied for as little time as possible. Two sources can start a refresh. The first is an internal divider that counts pulses on a slow timer tick. The second is an external bus master that pulls the shared refresh strobe low while it owns the expansion bus.

For each refresh, the block requests the host bus. Once grant arrives, it drives the current refresh row on an address output for exactly two host clocks, so that external buffers can latch the row. It then releases the host bus. The strobe phase on the expansion bus continues on its own, timed in ISA clock ticks. An 8-bit row counter advances after every completed refresh.

The bidirectional strobe is modelled as three plain ports: a driven level, an output enable, and the sampled line. The block drives the line only while it owns the strobe phase and no external master holds the bus.

Top module: `isa_rfsh_ctrl`

## Requirements
- R1: During the strobe phase of a refresh, with `ext_master_i` low, `rfsh_oe_o` is 1 and `rfsh_n_o` is 0. Outside the strobe phase, `rfsh_oe_o` is 0 and `rfsh_n_o` is 1.
- R2: While `ext_master_i` is 1, `rfsh_oe_o` stays 0. A 1-to-0 transition of `rfsh_n_i`, sampled on two consecutive clocks while `ext_master_i` is 1, starts a refresh.
- R3: Every refresh raises `hreq_o`. It then holds `addr_oe_o` high for exactly two consecutive host clocks, with `addr_o` equal to the row counter and `hreq_o` high in both clocks. When `addr_oe_o` is 0, `addr_o` reads 0.
- R4: The two-clock address window begins on the first clock edge that samples `hgnt_i` high while a request is outstanding. While grant is low, `hreq_o` stays high and `addr_oe_o` stays 0.
- R5: `hreq_o` falls in the same cycle that the address window ends. The strobe phase that follows runs with `hreq_o` low.
- R6: The strobe phase lasts exactly STRB_CYC clock edges at which `isa_tick_i` is 1 (default 4). The phase ends at the edge of the last such tick.
- R7: The internal timer starts a refresh on every TMR_DIV-th `tick_i` pulse after reset (default 15). Fewer pulses start nothing.
- R8: The row counter resets to 0. It increments by one when a strobe phase completes and wraps from 255 to 0.
- R9: A request that arrives while a refresh is in progress is held and serviced exactly once afterwards. Further requests in that time are dropped. A timer request and a strobe trigger in the same cycle give a single refresh.
- R10: After reset, `hreq_o`, `addr_oe_o` and `rfsh_oe_o` are 0, `rfsh_n_o` is 1 and `addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Slow timer tick, one-cycle pulses |
| isa_tick_i | input | 1 | Expansion-bus clock enable, one host cycle per ISA clock |
| ext_master_i | input | 1 | An external master owns the expansion bus |
| hgnt_i | input | 1 | Host bus grant |
| hreq_o | output | 1 | Host bus request |
| addr_o | output | ROW_W | Refresh row, valid during the address window |
| addr_oe_o | output | 1 | Address drive enable (latch window for external buffers) |
| rfsh_n_i | input | 1 | Sampled level of the refresh strobe line |
| rfsh_n_o | output | 1 | Level driven onto the strobe line (active low) |
| rfsh_oe_o | output | 1 | Strobe line drive enable |

## Verification
Refreshes started by the timer are tried with grant delays of zero to several cycles. This separates a window that waits for grant from one that opens early, and shows whether the window is always two clocks long. A sweep of 260 timer refreshes runs the row through all 256 values and past the wrap. Refreshes triggered by the strobe under an external master confirm that the line is never driven and that the falling edge alone starts a cycle. Bursts of timer requests during a stalled grant, and a timer request coinciding with a strobe trigger, tell a single pending slot apart from a queue or from lost requests.

// File: rtl/isa_rfsh_pkg.sv
`timescale 1ns/1ps
package isa_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HREQ = 3'd1,
        ST_ADR1 = 3'd2,
        ST_ADR2 = 3'd3,
        ST_STRB = 3'd4
    } rf_state_e;

    typedef struct packed {
        logic hreq;
        logic addr_oe;
        logic strobe;
    } rf_ctl_t;

    function automatic rf_ctl_t decode_state(rf_state_e s);
        rf_ctl_t c;
        c.hreq    = (s == ST_HREQ) || (s == ST_ADR1) || (s == ST_ADR2);
        c.addr_oe = (s == ST_ADR1) || (s == ST_ADR2);
        c.strobe  = (s == ST_STRB);
        return c;
    endfunction

    function automatic int unsigned width_of(int unsigned v);
        return (v < 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
`timescale 1ns/1ps
module rfsh_timer
    import isa_rfsh_pkg::*;
#(
    parameter int unsigned TMR_DIV = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic fire_o
);
    localparam int unsigned CW = width_of(TMR_DIV);
    localparam logic [CW-1:0] RELOAD = CW'(TMR_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= RELOAD;
            fire_o <= 1'b0;
        end else begin
            fire_o <= 1'b0;
            if (tick_i) begin
                if (cnt == '0) begin
                    cnt    <= RELOAD;
                    fire_o <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rfsh_ext_trig.sv
`timescale 1ns/1ps
module rfsh_ext_trig (
    input  logic clk,
    input  logic rst,
    input  logic master_i,
    input  logic line_n_i,
    output logic trig_o
);
    logic prev_n;

    always_ff @(posedge clk) begin
        if (rst) prev_n <= 1'b1;
        else     prev_n <= line_n_i;
    end

    assign trig_o = master_i & prev_n & ~line_n_i;
endmodule

// File: rtl/rfsh_pend.sv
`timescale 1ns/1ps
module rfsh_pend (
    input  logic clk,
    input  logic rst,
    input  logic tmr_i,
    input  logic ext_i,
    input  logic take_i,
    output logic valid_o
);
    logic pend;
    logic fresh;

    assign fresh   = tmr_i | ext_i;
    assign valid_o = pend | fresh;

    always_ff @(posedge clk) begin
        if (rst)         pend <= 1'b0;
        else if (take_i) pend <= 1'b0;
        else if (fresh)  pend <= 1'b1;
    end
endmodule

// File: rtl/rfsh_seq.sv
`timescale 1ns/1ps
module rfsh_seq
    import isa_rfsh_pkg::*;
#(
    parameter int unsigned ROW_W    = 8,
    parameter int unsigned STRB_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    output logic             take_o,
    input  logic             hgnt_i,
    input  logic             isa_tick_i,
    input  logic             ext_master_i,
    output logic             hreq_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             addr_oe_o,
    output logic             strb_oe_o,
    output logic             strb_n_o
);
    localparam int unsigned SCW = width_of(STRB_CYC);
    localparam logic [SCW-1:0] SC_LAST = SCW'(STRB_CYC - 1);

    rf_state_e        st, nxt;
    rf_ctl_t          ctl;
    logic [SCW-1:0]   scnt;
    logic [ROW_W-1:0] row;
    logic             strb_done;

    assign strb_done = (st == ST_STRB) && isa_tick_i && (scnt == SC_LAST);

    always_comb begin
        nxt    = st;
        take_o = 1'b0;
        unique case (st)
            ST_IDLE: if (valid_i) begin
                take_o = 1'b1;
                nxt    = ST_HREQ;
            end
            ST_HREQ: if (hgnt_i) nxt = ST_ADR1;
            ST_ADR1: nxt = ST_ADR2;
            ST_ADR2: nxt = ST_STRB;
            ST_STRB: if (strb_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            scnt <= '0;
            row  <= '0;
        end else begin
            st <= nxt;
            if (st != ST_STRB)   scnt <= '0;
            else if (isa_tick_i) scnt <= scnt + 1'b1;
            if (strb_done)       row  <= row + 1'b1;
        end
    end

    assign ctl       = decode_state(st);
    assign hreq_o    = ctl.hreq;
    assign addr_oe_o = ctl.addr_oe;
    assign addr_o    = ctl.addr_oe ? row : '0;
    assign strb_oe_o = ctl.strobe & ~ext_master_i;
    assign strb_n_o  = ~strb_oe_o;
endmodule

// File: rtl/isa_rfsh_ctrl.sv
`timescale 1ns/1ps
module isa_rfsh_ctrl
    import isa_rfsh_pkg::*;
#(
    parameter int unsigned ROW_W    = 8,
    parameter int unsigned TMR_DIV  = 15,
    parameter int unsigned STRB_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             isa_tick_i,
    input  logic             ext_master_i,
    input  logic             hgnt_i,
    output logic             hreq_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             addr_oe_o,
    input  logic             rfsh_n_i,
    output logic             rfsh_n_o,
    output logic             rfsh_oe_o
);
    logic tmr_fire;
    logic ext_trig;
    logic req_valid;
    logic req_take;

    rfsh_timer #(.TMR_DIV(TMR_DIV)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .fire_o (tmr_fire)
    );

    rfsh_ext_trig trig_i (
        .clk      (clk),
        .rst      (rst),
        .master_i (ext_master_i),
        .line_n_i (rfsh_n_i),
        .trig_o   (ext_trig)
    );

    rfsh_pend pend_i (
        .clk     (clk),
        .rst     (rst),
        .tmr_i   (tmr_fire),
        .ext_i   (ext_trig),
        .take_i  (req_take),
        .valid_o (req_valid)
    );

    rfsh_seq #(.ROW_W(ROW_W), .STRB_CYC(STRB_CYC)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (req_valid),
        .take_o       (req_take),
        .hgnt_i       (hgnt_i),
        .isa_tick_i   (isa_tick_i),
        .ext_master_i (ext_master_i),
        .hreq_o       (hreq_o),
        .addr_o       (addr_o),
        .addr_oe_o    (addr_oe_o),
        .strb_oe_o    (rfsh_oe_o),
        .strb_n_o     (rfsh_n_o)
    );
endmodule

// File: rtl/isa_rfsh_ctrl_chk.sv
`timescale 1ns/1ps
module isa_rfsh_ctrl_chk #(
    parameter int unsigned ROW_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_master_i,
    input logic             hgnt_i,
    input logic             hreq_o,
    input logic [ROW_W-1:0] addr_o,
    input logic             addr_oe_o,
    input logic             rfsh_n_o,
    input logic             rfsh_oe_o
);
    p_strobe_low_r1: assert property (@(posedge clk) disable iff (rst)
        rfsh_oe_o |-> !rfsh_n_o);

    p_no_drive_master_r2: assert property (@(posedge clk) disable iff (rst)
        ext_master_i |-> !rfsh_oe_o);

    p_win_open_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_oe_o) |=> addr_oe_o);

    p_win_close_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_oe_o && $past(addr_oe_o)) |=> !addr_oe_o);

    p_addr_held_r3: assert property (@(posedge clk) disable iff (rst)
        (addr_oe_o && $past(addr_oe_o)) |-> $stable(addr_o));

    p_addr_req_r3: assert property (@(posedge clk) disable iff (rst)
        addr_oe_o |-> hreq_o);

    p_wait_gnt_r4: assert property (@(posedge clk) disable iff (rst)
        (hreq_o && !addr_oe_o && !hgnt_i) |=> (hreq_o && !addr_oe_o));

    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_oe_o) |-> !hreq_o);

    p_strobe_no_host_r5: assert property (@(posedge clk) disable iff (rst)
        rfsh_oe_o |-> !hreq_o);
endmodule

bind isa_rfsh_ctrl isa_rfsh_ctrl_chk #(.ROW_W(ROW_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .ext_master_i (ext_master_i),
    .hgnt_i       (hgnt_i),
    .hreq_o       (hreq_o),
    .addr_o       (addr_o),
    .addr_oe_o    (addr_oe_o),
    .rfsh_n_o     (rfsh_n_o),
    .rfsh_oe_o    (rfsh_oe_o)
);

// File: tb/isa_rfsh_ctrl_tb_top.sv
`timescale 1ns/1ps
module isa_rfsh_ctrl_tb_top;
    localparam int ROW_W    = 8;
    localparam int TMR_DIV  = 15;
    localparam int STRB_CYC = 4;
    localparam int ISA_DIV  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_i = 1'b0;
    logic isa_tick_i = 1'b0;
    logic ext_master_i = 1'b0;
    logic hgnt_i = 1'b0;
    logic ext_drv_n = 1'b1;
    logic hreq_o, addr_oe_o, rfsh_n_o, rfsh_oe_o, rfsh_n_i;
    logic [ROW_W-1:0] addr_o;

    int total = 0;
    int bad = 0;
    int exp_row = 0;
    int ticks_left = TMR_DIV;
    int stb_ticks = 0;
    int hreq_rises = 0;
    bit hreq_prev = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign rfsh_n_i = rfsh_oe_o ? rfsh_n_o : ext_drv_n;

    isa_rfsh_ctrl #(.ROW_W(ROW_W), .TMR_DIV(TMR_DIV), .STRB_CYC(STRB_CYC)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .isa_tick_i(isa_tick_i),
        .ext_master_i(ext_master_i), .hgnt_i(hgnt_i), .hreq_o(hreq_o),
        .addr_o(addr_o), .addr_oe_o(addr_oe_o), .rfsh_n_i(rfsh_n_i),
        .rfsh_n_o(rfsh_n_o), .rfsh_oe_o(rfsh_oe_o)
    );

    always @(posedge clk) begin
        if (rfsh_oe_o && isa_tick_i) stb_ticks <= stb_ticks + 1;
        if (hreq_o && !hreq_prev) hreq_rises <= hreq_rises + 1;
        hreq_prev <= hreq_o;
    end

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            isa_tick_i = (ph == 0);
            ph = (ph + 1) % ISA_DIV;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            @(negedge clk);
            ticks_left--;
            if (ticks_left == 0) ticks_left = TMR_DIV;
        end
    endtask

    task automatic fire_timer();
        tick_n(ticks_left);
    endtask

    task automatic observe(input int gdelay, input bit drive, input string tag);
        int n = 0;
        int w = 0;
        int t0;
        while (!hreq_o && n < 60) begin @(negedge clk); n++; end
        chk({tag, " R3 hreq raised"}, int'(hreq_o), 1);
        for (int i = 0; i < gdelay; i++) begin
            chk({tag, " R4 no addr before grant"}, int'(addr_oe_o), 0);
            chk({tag, " R4 hreq held"}, int'(hreq_o), 1);
            @(negedge clk);
        end
        hgnt_i = 1'b1;
        @(negedge clk);
        while (addr_oe_o && w < 8) begin
            chk({tag, " R3 address is row"}, int'(addr_o), exp_row);
            chk({tag, " R3 hreq in window"}, int'(hreq_o), 1);
            w++;
            @(negedge clk);
        end
        chk({tag, " R3 window length"}, w, 2);
        chk({tag, " R5 host released"}, int'(hreq_o), 0);
        chk({tag, " R3 addr zero outside"}, int'(addr_o), 0);
        hgnt_i = 1'b0;
        chk({tag, " R1/R2 strobe enable"}, int'(rfsh_oe_o), int'(drive));
        if (drive) begin
            t0 = stb_ticks;
            n = 0;
            while (rfsh_oe_o && n < 200) begin
                chk({tag, " R1 strobe low"}, int'(rfsh_n_o), 0);
                chk({tag, " R5 no host during strobe"}, int'(hreq_o), 0);
                @(negedge clk);
                n++;
            end
            chk({tag, " R6 strobe ticks"}, stb_ticks - t0, STRB_CYC);
            chk({tag, " R1 strobe idle high"}, int'(rfsh_n_o), 1);
        end else begin
            for (int i = 0; i < STRB_CYC * ISA_DIV + 4; i++) begin
                if (rfsh_oe_o) chk({tag, " R2 no drive under master"}, 1, 0);
                @(negedge clk);
            end
        end
        exp_row = (exp_row + 1) % 256;
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 hreq reset", int'(hreq_o), 0);
        chk("R10 addr_oe reset", int'(addr_oe_o), 0);
        chk("R10 rfsh_oe reset", int'(rfsh_oe_o), 0);
        chk("R10 rfsh_n reset", int'(rfsh_n_o), 1);
        chk("R10 addr reset", int'(addr_o), 0);

        // R7: one short of the divider starts nothing
        r0 = hreq_rises;
        tick_n(TMR_DIV - 1);
        repeat (20) @(negedge clk);
        chk("R7 no refresh before divider", hreq_rises - r0, 0);
        tick_n(1);
        observe(0, 1'b1, "R7 timer");
        chk("R7 one refresh per divider", hreq_rises - r0, 1);

        // R4: late grant of several lengths
        for (int g = 1; g <= 5; g++) begin
            fire_timer();
            observe(g, 1'b1, "R4 late grant");
        end

        // R2: trigger by external master strobe
        ext_master_i = 1'b1;
        repeat (4) @(negedge clk);
        r0 = hreq_rises;
        ext_drv_n = 1'b0;
        observe(2, 1'b0, "R2 ext trigger");
        repeat (20) @(negedge clk);
        chk("R2 held strobe retriggers nothing", hreq_rises - r0, 1);
        ext_drv_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9: timer request coinciding with a strobe trigger
        r0 = hreq_rises;
        tick_n(ticks_left - 1);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
        ext_drv_n = 1'b0;
        ticks_left = TMR_DIV;
        observe(0, 1'b0, "R9 coincident");
        ext_drv_n = 1'b1;
        repeat (60) @(negedge clk);
        chk("R9 coincident gives one", hreq_rises - r0, 1);
        ext_master_i = 1'b0;
        repeat (4) @(negedge clk);

        // R9: burst while the grant is stalled
        r0 = hreq_rises;
        fire_timer();
        repeat (4) @(negedge clk);
        fire_timer();
        fire_timer();
        fire_timer();
        observe(0, 1'b1, "R9 first");
        observe(0, 1'b1, "R9 pending");
        repeat (60) @(negedge clk);
        chk("R9 no queue beyond one", hreq_rises - r0, 2);

        // R8: sweep all rows through the wrap
        for (int i = 0; i < 260; i++) begin
            fire_timer();
            observe(i % 3, 1'b1, "R8 sweep");
            if (exp_row == 0) chk("R8 wrap seen at zero", exp_row, 0);
        end

        chk("R10 idle at end hreq", int'(hreq_o), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule